// File: doc/BRIEF.md
# Memory-Mapped Serial Read Frame Restarter

This block sits between a system bus read port and the serial frame sequencer. It turns a stream of bus accesses into serial command frames. The first bus access after an idle period opens a frame at that access's address. The sequencer then runs the command, address and dummy phases, and reports the end of that header on `hdr_done`. Bus accesses are served only once the header has finished.

When the transfer type selects array data reads (type 1), the serial side always fetches whole 32-bit words. The byte lane of the access picks the addressed byte or half-word out of the word. The block also tracks the next expected byte address. A read that does not continue at that address closes the open frame and opens a new one at its own address in the same cycle. All other transfer types keep the address of the first access only. For those types, each access is one serial transfer of its own size, and the frame closes only when software asks for the last transfer.

Top module: `rfr_top`

## Requirements
- R1: After reset no frame is open. The first `bus_valid` starts a frame: `frame_start` is high in that cycle and `bus_ready` is low.
- R2: For type 1 (array read), `frame_addr` at a frame start is the access address with bits [1:0] cleared. For the other types it is the access address unchanged.
- R3: Between a frame start and the cycle after `hdr_done` is seen, `bus_ready` stays low.
- R4: In an open type 1 frame, an access at the expected address is served with `bus_ready` and starts no frame. The expected address then advances by the access size in bytes (size 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes).
- R5: For a served type 1 access, `xfer_bytes` is 4 and `lane_sel` is address bits [1:0]. `data_req` is high only on the first access of a frame, or when address bits [1:0] are 0.
- R6: In an open type 1 frame, an access at any other address raises `frame_end` and `frame_start` in the same cycle, with `bus_ready` low. The new frame follows the R2 and R3 rules at that address.
- R7: For types 0, 2 and 3, every access in an open frame is served with `data_req`. `xfer_bytes` equals the size in bytes and `lane_sel` is 0, whatever the address.
- R8: `last_req` in an open frame raises `frame_end`, and the next access starts a new frame. An access in the same cycle is still served.
- R9: `last_req` while idle or during the header has no effect: no `frame_end`.
- R10: The transfer type is captured at frame start. A change on `xfer_type` during a frame has no effect until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus access pending, held until `bus_ready` |
| bus_addr | input | AW | Byte address of the access |
| bus_size | input | 2 | 0 byte, 1 half-word, 2 word |
| xfer_type | input | 2 | 0 register read, 1 array read, 2 register write, 3 array write |
| hdr_done | input | 1 | Sequencer finished command/address/dummy phases |
| last_req | input | 1 | Software request to close the frame |
| frame_start | output | 1 | Open a frame this cycle |
| frame_addr | output | AW | Address of the frame, valid with `frame_start` |
| frame_end | output | 1 | Close the open frame this cycle |
| data_req | output | 1 | Request one serial data transfer |
| xfer_bytes | output | 3 | Size of the requested transfer in bytes |
| lane_sel | output | 2 | Byte lane of the access in the fetched word |
| bus_ready | output | 1 | Access served this cycle |

## Verification
In type 1 mode, closing the old frame and opening the new one fall in the same cycle when a read breaks the sequence. A software close can also arrive in that same cycle. The bench sends a non-consecutive read, both alone and together with `last_req`. It expects `frame_start` and `frame_end` high together, `bus_ready` low and the aligned new address. In the cycle after, it expects the header wait, with `last_req` ignored.

// File: rtl/rfr_pkg.sv
package rfr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_OPEN = 2'd2
    } rfr_state_e;

    localparam logic [1:0] XT_ARRAY_RD = 2'd1;
    localparam int unsigned WORD_BYTES = 4;
endpackage

// File: rtl/rfr_size_decode.sv
module rfr_size_decode (
    input  logic [1:0] size_code,
    output logic [2:0] size_bytes
);
    always_comb begin
        case (size_code)
            2'd0:    size_bytes = 3'd1;
            2'd1:    size_bytes = 3'd2;
            default: size_bytes = 3'd4;
        endcase
    end
endmodule

// File: rtl/rfr_addr_track.sv
module rfr_addr_track #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] acc_addr,
    input  logic [AW-1:0] exp_addr,
    input  logic          first_acc,
    input  logic [2:0]    acc_bytes,
    output logic          seq_hit,
    output logic          need_fetch,
    output logic [AW-1:0] next_addr,
    output logic [AW-1:0] word_addr
);
    assign seq_hit    = (acc_addr == exp_addr);
    assign need_fetch = first_acc || (acc_addr[1:0] == 2'b00);
    assign next_addr  = acc_addr + AW'(acc_bytes);
    assign word_addr  = {acc_addr[AW-1:2], 2'b00};
endmodule

// File: rtl/rfr_top.sv
module rfr_top #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_valid,
    input  logic [AW-1:0] bus_addr,
    input  logic [1:0]    bus_size,
    input  logic [1:0]    xfer_type,
    input  logic          hdr_done,
    input  logic          last_req,
    output logic          frame_start,
    output logic [AW-1:0] frame_addr,
    output logic          frame_end,
    output logic          data_req,
    output logic [2:0]    xfer_bytes,
    output logic [1:0]    lane_sel,
    output logic          bus_ready
);
    import rfr_pkg::*;

    typedef struct packed {
        rfr_state_e    st;
        logic [1:0]    ty;
        logic [AW-1:0] exp_addr;
        logic          first;
    } rfr_regs_t;

    rfr_regs_t r_q, r_d;

    logic [2:0]    acc_bytes;
    logic          seq_hit, need_fetch;
    logic [AW-1:0] next_addr, word_addr;
    logic          open_arr;

    rfr_size_decode u_size (
        .size_code (bus_size),
        .size_bytes(acc_bytes)
    );

    rfr_addr_track #(.AW(AW)) u_track (
        .acc_addr  (bus_addr),
        .exp_addr  (r_q.exp_addr),
        .first_acc (r_q.first),
        .acc_bytes (acc_bytes),
        .seq_hit   (seq_hit),
        .need_fetch(need_fetch),
        .next_addr (next_addr),
        .word_addr (word_addr)
    );

    assign open_arr = (r_q.ty == XT_ARRAY_RD);

    always_comb begin
        r_d         = r_q;
        frame_start = 1'b0;
        frame_end   = 1'b0;
        frame_addr  = bus_addr;
        data_req    = 1'b0;
        xfer_bytes  = 3'd0;
        lane_sel    = 2'd0;
        bus_ready   = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (bus_valid) begin
                    frame_start = 1'b1;
                    frame_addr  = (xfer_type == XT_ARRAY_RD) ? word_addr : bus_addr;
                    r_d.st       = ST_HDR;
                    r_d.ty       = xfer_type;
                    r_d.exp_addr = bus_addr;
                    r_d.first    = 1'b1;
                end
            end
            ST_HDR: begin
                if (hdr_done) r_d.st = ST_OPEN;
            end
            ST_OPEN: begin
                if (bus_valid && open_arr && !seq_hit) begin
                    frame_start  = 1'b1;
                    frame_end    = 1'b1;
                    frame_addr   = word_addr;
                    r_d.st       = ST_HDR;
                    r_d.exp_addr = bus_addr;
                    r_d.first    = 1'b1;
                end else begin
                    if (bus_valid) begin
                        bus_ready = 1'b1;
                        if (open_arr) begin
                            data_req     = need_fetch;
                            xfer_bytes   = 3'(WORD_BYTES);
                            lane_sel     = bus_addr[1:0];
                            r_d.exp_addr = next_addr;
                            r_d.first    = 1'b0;
                        end else begin
                            data_req   = 1'b1;
                            xfer_bytes = acc_bytes;
                        end
                    end
                    if (last_req) begin
                        frame_end = 1'b1;
                        r_d.st    = ST_IDLE;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st       <= ST_IDLE;
            r_q.ty       <= 2'd0;
            r_q.exp_addr <= '0;
            r_q.first    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/rfr_checker.sv
module rfr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_valid,
    input logic       bus_ready,
    input logic       frame_start,
    input logic       frame_end,
    input logic       data_req,
    input logic [2:0] xfer_bytes,
    input logic [1:0] lane_sel
);
    AST_HDR_BLOCKS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !bus_ready); // R3
    AST_RESTART_NO_SERVE: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && frame_end) |-> !bus_ready); // R6
    AST_LANE_IMPLIES_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (data_req && lane_sel != 2'd0) |-> (xfer_bytes == 3'd4)); // R5
    AST_END_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !frame_end); // R8
    AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |-> (bus_valid && !frame_start)); // R4
endmodule

bind rfr_top rfr_checker u_rfr_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_ready  (bus_ready),
    .frame_start(frame_start),
    .frame_end  (frame_end),
    .data_req   (data_req),
    .xfer_bytes (xfer_bytes),
    .lane_sel   (lane_sel)
);

// File: tb/tb_rfr_top.sv
module tb_rfr_top;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [1:0]    bus_size = '0;
    logic [1:0]    xfer_type = '0;
    logic          hdr_done = 1'b0;
    logic          last_req = 1'b0;
    logic          frame_start, frame_end, data_req, bus_ready;
    logic [AW-1:0] frame_addr;
    logic [2:0]    xfer_bytes;
    logic [1:0]    lane_sel;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    rfr_top #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_size(bus_size), .xfer_type(xfer_type), .hdr_done(hdr_done),
        .last_req(last_req), .frame_start(frame_start), .frame_addr(frame_addr),
        .frame_end(frame_end), .data_req(data_req), .xfer_bytes(xfer_bytes),
        .lane_sel(lane_sel), .bus_ready(bus_ready)
    );

    typedef struct packed {
        logic        v;
        logic [31:0] a;
        logic [1:0]  sz;
        logic [1:0]  ty;
        logic        hd;
        logic        lr;
        logic        efs;
        logic        efe;
        logic        erdy;
        logic        edq;
        logic [2:0]  exb;
        logic [1:0]  eln;
        logic [31:0] efa;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 19;
    //  v  addr          sz    ty    hd    lr    fs    fe    rdy   dq    xb    ln    fa            req
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h0,   2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 32'h0,   4'd1},  // R1 idle
        '{1'b1, 32'h103, 2'd0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 32'h100, 4'd2},  // R2 aligned
        '{1'b1, 32'h103, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 32'h0,   4'd3},  // R3 wait
        '{1'b1, 32'h103, 2'd0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 32'h0,   4'd3},  // R3 hdr seen
        '{1'b1, 32'h103, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd4, 2'd3, 32'h0,   4'd5},  // R5 first fetch
        '{1'b1, 32'h104, 2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd4, 2'd0, 32'h0,   4'd4},  // R4 seq
        '{1'b1, 32'h106, 2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd4, 2'd2, 32'h0,   4'd5},  // R5 no fetch
        '{1'b1, 32'h108, 2'd2, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd4, 2'd0, 32'h0,   4'd4},  // R4 word
        '{1'b1, 32'h200, 2'd0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 2'd0, 32'h200, 4'd6},  // R6 restart
        '{1'b1, 32'h200, 2'd0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 32'h0,   4'd6},  // R6 header
        '{1'b1, 32'h200, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd4, 2'd0, 32'h0,   4'd6},  // R6 served
        '{1'b1, 32'h201, 2'd0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 3'd4, 2'd1, 32'h0,   4'd8},  // R8 close+serve
        '{1'b0, 32'h0,   2'd0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 32'h0,   4'd9},  // R9 idle close
        '{1'b1, 32'h55,  2'd1, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 32'h55,  4'd7},  // R7 start
        '{1'b0, 32'h0,   2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 32'h0,   4'd7},  // R7 header
        '{1'b1, 32'h999, 2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd2, 2'd0, 32'h0,   4'd7},  // R7 half
        '{1'b1, 32'h10,  2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1, 2'd0, 32'h0,   4'd10}, // R10 type latched
        '{1'b1, 32'h0,   2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd4, 2'd0, 32'h0,   4'd7},  // R7 word
        '{1'b0, 32'h0,   2'd0, 2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 2'd0, 32'h0,   4'd8}   // R8 close
    };

    task automatic drive(input logic v, input logic [31:0] a, input logic [1:0] sz,
                         input logic [1:0] ty, input logic hd, input logic lr);
        @(posedge clk);
        #1;
        bus_valid = v; bus_addr = a; bus_size = sz; xfer_type = ty;
        hdr_done = hd; last_req = lr;
        #2;
    endtask

    task automatic chk(input string rq, input string what, input logic [63:0] got,
                       input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got=%0h exp=%0h", rq, what, got, exp);
        end
    endtask

    initial begin
        #400000;
        bad++;
        $display("FAIL watchdog: got=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = $sformatf("R%0d", VECS[i].rq);
            drive(VECS[i].v, VECS[i].a, VECS[i].sz, VECS[i].ty, VECS[i].hd, VECS[i].lr);
            chk(rq, "start/end/ready/req",
                {60'd0, frame_start, frame_end, bus_ready, data_req},
                {60'd0, VECS[i].efs, VECS[i].efe, VECS[i].erdy, VECS[i].edq});
            if (VECS[i].efs) chk(rq, "frame_addr", 64'(frame_addr), 64'(VECS[i].efa));
            if (VECS[i].erdy) chk(rq, "bytes/lane", {59'd0, xfer_bytes, lane_sel},
                                  {59'd0, VECS[i].exb, VECS[i].eln});
        end

        // R1: reset in the middle of a frame returns to idle
        drive(1'b1, 32'h40, 2'd0, 2'd2, 1'b0, 1'b0);
        drive(1'b0, 32'h0, 2'd0, 2'd2, 1'b1, 1'b0);
        #1 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        drive(1'b1, 32'h80, 2'd0, 2'd2, 1'b0, 1'b0);
        chk("R1", "start after reset", {63'd0, frame_start}, 64'd1);
        chk("R1", "addr after reset", 64'(frame_addr), 64'h80);
        chk("R1", "no ready at start", {63'd0, bus_ready}, 64'd0);
        drive(1'b0, 32'h0, 2'd0, 2'd2, 1'b0, 1'b1);
        drive(1'b0, 32'h0, 2'd0, 2'd2, 1'b1, 1'b0);
        drive(1'b0, 32'h0, 2'd0, 2'd2, 1'b0, 1'b1);
        chk("R8", "close type2", {63'd0, frame_end}, 64'd1);

        // R6: break in sequence together with last_req
        drive(1'b1, 32'h0, 2'd2, 2'd1, 1'b0, 1'b0);
        drive(1'b0, 32'h0, 2'd2, 2'd1, 1'b1, 1'b0);
        drive(1'b1, 32'h0, 2'd2, 2'd1, 1'b0, 1'b0);
        chk("R4", "served first", {63'd0, bus_ready}, 64'd1);
        drive(1'b1, 32'h42, 2'd1, 2'd1, 1'b0, 1'b1);
        chk("R6", "restart pair", {62'd0, frame_start, frame_end}, 64'd3);
        chk("R6", "restart addr", 64'(frame_addr), 64'h40);
        chk("R6", "restart ready", {63'd0, bus_ready}, 64'd0);
        drive(1'b1, 32'h42, 2'd1, 2'd1, 1'b0, 1'b1);
        chk("R9", "last_req in header", {62'd0, frame_end, bus_ready}, 64'd0);
        drive(1'b1, 32'h42, 2'd1, 2'd1, 1'b1, 1'b0);
        drive(1'b1, 32'h42, 2'd1, 2'd1, 1'b0, 1'b0);
        chk("R5", "first fetch mid-word", {60'd0, data_req, xfer_bytes},
            {60'd0, 1'b1, 3'd4});
        chk("R5", "lane mid-word", {62'd0, lane_sel}, 64'd2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule